// File: doc/BRIEF.md
# Lockable Thermal Protection Register File

This block is the software-visible register file for an on-die thermal monitor. Boot firmware uses it to program a critical temperature threshold, store a 32-bit calibration slope and arm the hardware shutdown response. It then sets a sticky lock. Once the lock is set, none of those protection settings can be changed until the next power-on reset. That includes the shutdown enable, so software that runs later cannot quietly disarm the thermal trip.

The block samples an 8-bit temperature from the sensor front end every clock and compares it with the threshold. When shutdown is armed and the reading has reached the threshold, it raises a registered shutdown request toward the power controller. The block only stores the calibration slope; it does not use it.

The block has two resets. The power-on reset returns every register to its default. A separate synchronous warm reset clears only the transient bus state and leaves the lock and every protected setting as they were. A write that the lock rejects produces a one-cycle violation pulse.

Top module: `thermal_guard_regs`

## Requirements
- R1: After power-on reset, reads return the following values: threshold 125 (word index 0), calibration 0 (index 1), lock 0 (index 2), shutdown control 0 (index 3), temperature 0 (index 4). The output `shutdown_req` is 0.
- R2: While unlocked, a write to index 0 stores bits [7:0] as the threshold and a write to index 1 stores all 32 bits as the calibration slope. Threshold bits [31:8] read as 0.
- R3: Writing a word with bit 0 = 1 to index 2 sets the lock, which reads back as bit 0. No write clears the lock, including a write of 0. Bits [31:1] of the lock word read as 0.
- R4: While locked, writes to index 0, 1 and 3 leave the threshold, the slope and the shutdown enable unchanged.
- R5: One cycle after a write to index 0, 1 or 3 while locked, `lock_violation` is high for exactly that write cycle. No other write raises it.
- R6: Bit 1 of index 3 is the shutdown enable. All other bits of that word read as 0 and ignore writes.
- R7: Index 4 returns the sampled sensor temperature in bits [7:0]. Writes to it have no effect.
- R8: `shutdown_req` is the registered value of (enable AND temperature >= threshold). It rises two clocks after `temp_in` reaches the threshold: one clock to sample the input and one clock to register the comparison.
- R9: Asserting `warm_rst_n` low leaves the lock, threshold, slope and shutdown enable unchanged.
- R10: A read returns data one clock after `bus_rd_en`. Indices 5 to 7 and byte addresses that are not word aligned read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low asynchronous power-on reset |
| warm_rst_n | input | 1 | Active-low synchronous warm reset; protected state survives it |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte address; word index in bits [4:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| temp_in | input | 8 | Sensor temperature in degrees Celsius |
| shutdown_req | output | 1 | Hardware shutdown request |
| lock_violation | output | 1 | One-cycle pulse for each rejected write |

## Verification
The checker checks on every clock that the lock never falls and that the threshold, slope and enable stay stable while the lock is set. It also checks that every write rejected under the lock produces the violation pulse and that no other write does. Finally, it checks that the shutdown request always equals the previous cycle's comparison, and that reads of unmapped words return 0. The bench scenarios cover the rest: the reset values, the masking of reserved bits on readback, the two-clock trip latency from the temperature input, that a warm reset preserves the protected state, and that a later power-on reset clears the lock.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
    // Word indices; the offsets are part of the software contract
    localparam int IDX_LIMIT = 0;
    localparam int IDX_CALIB = 1;
    localparam int IDX_LOCK  = 2;
    localparam int IDX_SDCTL = 3;
    localparam int IDX_TEMP  = 4;
    localparam int NUM_REGS  = 5;
    // Bit positions inside the control words
    localparam int LOCK_BIT  = 0;
    localparam int SD_EN_BIT = 1;
endpackage

// File: rtl/thermal_addr_decode.sv
module thermal_addr_decode #(
    parameter int ADDR_W   = 5,
    parameter int NUM_REGS = 5
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic [NUM_REGS-1:0] rd_sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        localparam logic [IDX_W-1:0] G_IDX = IDX_W'(g);
        logic hit;
        assign hit       = aligned && (addr[ADDR_W-1:2] == G_IDX);
        assign wr_sel[g] = wr_en && hit;
        assign rd_sel[g] = rd_en && hit;
    end
endmodule

// File: rtl/thermal_lock_ctrl.sv
module thermal_lock_ctrl (
    input  logic clk,
    input  logic por_n,
    input  logic warm_rst_n,
    input  logic lock_wr,
    input  logic lock_set_bit,
    input  logic prot_wr,
    output logic locked,
    output logic violation
);
    typedef struct packed {
        logic lock;
        logic viol;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // a rejected write is flagged for exactly one cycle
        st_d.viol = prot_wr && st_q.lock;
        // write-one-to-set; no path ever clears it except power-on reset
        if (lock_wr && lock_set_bit) begin
            st_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else if (!warm_rst_n) begin
            st_q.lock <= st_q.lock;
            st_q.viol <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign locked    = st_q.lock;
    assign violation = st_q.viol;
endmodule

// File: rtl/thermal_trip.sv
module thermal_trip #(
    parameter int TEMP_W = 8
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [TEMP_W-1:0] temp_in,
    input  logic [TEMP_W-1:0] limit,
    input  logic              sd_en,
    output logic [TEMP_W-1:0] cur_temp,
    output logic              trip
);
    typedef struct packed {
        logic [TEMP_W-1:0] temp;
        logic              trip;
    } trip_st_t;

    trip_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.temp = temp_in;
        st_d.trip = sd_en && (st_q.temp >= limit);
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_temp = st_q.temp;
    assign trip     = st_q.trip;
endmodule

// File: rtl/thermal_guard_regs.sv
module thermal_guard_regs
    import thermal_guard_pkg::*;
#(
    parameter int                ADDR_W      = 5,
    parameter int                DATA_W      = 32,
    parameter int                TEMP_W      = 8,
    parameter logic [TEMP_W-1:0] LIMIT_RESET = TEMP_W'(125)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [TEMP_W-1:0] temp_in,
    output logic              shutdown_req,
    output logic              lock_violation
);
    typedef struct packed {
        logic [TEMP_W-1:0] limit;
        logic [DATA_W-1:0] calib;
        logic              sd_en;
    } cfg_t;

    logic [NUM_REGS-1:0] wr_sel, rd_sel;
    logic                locked, prot_wr;
    logic [TEMP_W-1:0]   cur_temp;
    cfg_t                cfg_d, cfg_q;
    logic [DATA_W-1:0]   rdata_d, rdata_q;

    thermal_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) decode_i (
        .addr   (bus_addr),
        .wr_en  (bus_wr_en),
        .rd_en  (bus_rd_en),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    assign prot_wr = wr_sel[IDX_LIMIT] | wr_sel[IDX_CALIB] | wr_sel[IDX_SDCTL];

    thermal_lock_ctrl lock_i (
        .clk          (clk),
        .por_n        (por_n),
        .warm_rst_n   (warm_rst_n),
        .lock_wr      (wr_sel[IDX_LOCK]),
        .lock_set_bit (bus_wdata[LOCK_BIT]),
        .prot_wr      (prot_wr),
        .locked       (locked),
        .violation    (lock_violation)
    );

    thermal_trip #(
        .TEMP_W (TEMP_W)
    ) trip_i (
        .clk      (clk),
        .por_n    (por_n),
        .temp_in  (temp_in),
        .limit    (cfg_q.limit),
        .sd_en    (cfg_q.sd_en),
        .cur_temp (cur_temp),
        .trip     (shutdown_req)
    );

    // protected configuration: writable only while the lock is clear
    always_comb begin
        cfg_d = cfg_q;
        if (!locked) begin
            if (wr_sel[IDX_LIMIT]) cfg_d.limit = bus_wdata[TEMP_W-1:0];
            if (wr_sel[IDX_CALIB]) cfg_d.calib = bus_wdata;
            if (wr_sel[IDX_SDCTL]) cfg_d.sd_en = bus_wdata[SD_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q <= '{limit: LIMIT_RESET, calib: '0, sd_en: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    // read path: reserved bits and unmapped words return zero
    always_comb begin
        rdata_d = rdata_q;
        if (bus_rd_en) begin
            rdata_d = '0;
            if (rd_sel[IDX_LIMIT]) rdata_d[TEMP_W-1:0] = cfg_q.limit;
            if (rd_sel[IDX_CALIB]) rdata_d             = cfg_q.calib;
            if (rd_sel[IDX_LOCK])  rdata_d[LOCK_BIT]   = locked;
            if (rd_sel[IDX_SDCTL]) rdata_d[SD_EN_BIT]  = cfg_q.sd_en;
            if (rd_sel[IDX_TEMP])  rdata_d[TEMP_W-1:0] = cur_temp;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rdata_q <= '0;
        end else if (!warm_rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk
    import thermal_guard_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int TEMP_W = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              lock,
    input logic              viol,
    input logic [TEMP_W-1:0] limit,
    input logic [DATA_W-1:0] calib,
    input logic              sd_en,
    input logic [TEMP_W-1:0] cur_temp,
    input logic              shutdown_req
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] widx;
    logic             aligned, prot_hit, unmapped;
    assign widx     = bus_addr[ADDR_W-1:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign prot_hit = aligned && ((widx == IDX_W'(IDX_LIMIT)) ||
                                  (widx == IDX_W'(IDX_CALIB)) ||
                                  (widx == IDX_W'(IDX_SDCTL)));
    assign unmapped = !aligned || (widx >= IDX_W'(NUM_REGS));

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        lock |=> lock);

    // R4
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!por_n)
        lock |=> ($stable(limit) && $stable(calib) && $stable(sd_en)));

    // R5
    viol_raised_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_wr_en && prot_hit && lock) |=> viol);

    // R5
    viol_only_locked_chk: assert property (@(posedge clk) disable iff (!por_n)
        !(bus_wr_en && prot_hit && lock) |=> !viol);

    // R8
    trip_latency_chk: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> (shutdown_req == $past(sd_en && (cur_temp >= limit))));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd_en && unmapped) |=> (bus_rdata == '0));
endmodule

bind thermal_guard_regs thermal_guard_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TEMP_W (TEMP_W)
) chk_i (
    .clk          (clk),
    .por_n        (por_n),
    .bus_wr_en    (bus_wr_en),
    .bus_rd_en    (bus_rd_en),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .lock         (locked),
    .viol         (lock_violation),
    .limit        (cfg_q.limit),
    .calib        (cfg_q.calib),
    .sd_en        (cfg_q.sd_en),
    .cur_temp     (cur_temp),
    .shutdown_req (shutdown_req)
);

// File: tb/thermal_guard_regs_tb.sv
`timescale 1ns/1ps
module thermal_guard_regs_tb_top;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  temp_in = '0;
    logic        shutdown_req;
    logic        lock_violation;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    thermal_guard_regs dut_i (
        .clk            (clk),
        .por_n          (por_n),
        .warm_rst_n     (warm_rst_n),
        .bus_wr_en      (bus_wr_en),
        .bus_rd_en      (bus_rd_en),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .temp_in        (temp_in),
        .shutdown_req   (shutdown_req),
        .lock_violation (lock_violation)
    );

    localparam logic [4:0] A_LIMIT = 5'h00;
    localparam logic [4:0] A_CALIB = 5'h04;
    localparam logic [4:0] A_LOCK  = 5'h08;
    localparam logic [4:0] A_SDCTL = 5'h0C;
    localparam logic [4:0] A_TEMP  = 5'h10;

    logic last_viol;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
        last_viol = lock_violation;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic do_por();
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 shutdown_req", {31'b0, shutdown_req}, 32'h0);
        rd_check("R1 limit", A_LIMIT, 32'd125);
        rd_check("R1 calib", A_CALIB, 32'h0);
        rd_check("R1 lock", A_LOCK, 32'h0);
        rd_check("R1 sdctl", A_SDCTL, 32'h0);
        rd_check("R1 temp", A_TEMP, 32'h0);
    endtask

    task automatic t_unlocked_writes();
        wr(A_LIMIT, 32'hFFFF_FF5A);
        check("R5 no viol unlocked", {31'b0, last_viol}, 32'h0);
        rd_check("R2 limit masked", A_LIMIT, 32'h0000_005A);
        wr(A_CALIB, 32'hDEAD_BEEF);
        rd_check("R2 calib", A_CALIB, 32'hDEAD_BEEF);
        wr(A_CALIB, 32'h0001_2345);
        rd_check("R2 calib rewrite", A_CALIB, 32'h0001_2345);
    endtask

    task automatic t_sdctl();
        wr(A_SDCTL, 32'hFFFF_FFFF);
        rd_check("R6 sdctl reserved", A_SDCTL, 32'h2);
        wr(A_SDCTL, 32'hFFFF_FFFD);
        rd_check("R6 sdctl cleared", A_SDCTL, 32'h0);
    endtask

    task automatic t_temp_ro();
        @(negedge clk); temp_in = 8'd40;
        @(negedge clk);
        rd_check("R7 temp sample", A_TEMP, 32'd40);
        wr(A_TEMP, 32'h0000_0012);
        check("R5 no viol temp wr", {31'b0, last_viol}, 32'h0);
        rd_check("R7 temp after write", A_TEMP, 32'd40);
    endtask

    task automatic t_trip();
        wr(A_LIMIT, 32'd100);
        wr(A_SDCTL, 32'h2);
        @(negedge clk); temp_in = 8'd99;
        @(negedge clk); @(negedge clk);
        check("R8 below limit", {31'b0, shutdown_req}, 32'h0);
        temp_in = 8'd100;
        @(negedge clk);
        check("R8 one clock early", {31'b0, shutdown_req}, 32'h0);
        @(negedge clk);
        check("R8 at limit", {31'b0, shutdown_req}, 32'h1);
        wr(A_SDCTL, 32'h0);
        @(negedge clk);
        check("R8 disabled", {31'b0, shutdown_req}, 32'h0);
        wr(A_SDCTL, 32'h2);
        temp_in = 8'd255;
        @(negedge clk); @(negedge clk);
        check("R8 max temp", {31'b0, shutdown_req}, 32'h1);
    endtask

    task automatic t_lock();
        wr(A_LOCK, 32'h0);
        rd_check("R3 zero write no lock", A_LOCK, 32'h0);
        wr(A_LOCK, 32'hFFFF_FFFF);
        check("R5 no viol on lock set", {31'b0, last_viol}, 32'h0);
        rd_check("R3 lock set", A_LOCK, 32'h1);
        wr(A_LIMIT, 32'd200);
        check("R5 viol limit", {31'b0, last_viol}, 32'h1);
        @(negedge clk);
        check("R5 viol one cycle", {31'b0, lock_violation}, 32'h0);
        rd_check("R4 limit kept", A_LIMIT, 32'd100);
        wr(A_CALIB, 32'hCAFE_0000);
        check("R5 viol calib", {31'b0, last_viol}, 32'h1);
        rd_check("R4 calib kept", A_CALIB, 32'h0001_2345);
        wr(A_SDCTL, 32'h0);
        check("R5 viol sdctl", {31'b0, last_viol}, 32'h1);
        rd_check("R4 sdctl kept", A_SDCTL, 32'h2);
        @(negedge clk); @(negedge clk);
        check("R4 shutdown still armed", {31'b0, shutdown_req}, 32'h1);
        wr(A_LOCK, 32'h0);
        check("R5 no viol lock reg", {31'b0, last_viol}, 32'h0);
        rd_check("R3 lock not cleared", A_LOCK, 32'h1);
    endtask

    task automatic t_warm();
        @(negedge clk); warm_rst_n = 1'b0;
        repeat (3) @(negedge clk);
        warm_rst_n = 1'b1;
        rd_check("R9 lock kept", A_LOCK, 32'h1);
        rd_check("R9 limit kept", A_LIMIT, 32'd100);
        rd_check("R9 calib kept", A_CALIB, 32'h0001_2345);
        rd_check("R9 sdctl kept", A_SDCTL, 32'h2);
    endtask

    task automatic t_unmapped();
        rd_check("R10 idx5", 5'h14, 32'h0);
        rd_check("R10 idx7", 5'h1C, 32'h0);
        rd_check("R10 misaligned", 5'h01, 32'h0);
        wr(5'h18, 32'hFFFF_FFFF);
        check("R10 no viol unmapped", {31'b0, last_viol}, 32'h0);
        rd_check("R10 limit untouched", A_LIMIT, 32'd100);
    endtask

    task automatic t_por_again();
        do_por();
        rd_check("R1 lock after por", A_LOCK, 32'h0);
        rd_check("R1 limit after por", A_LIMIT, 32'd125);
        wr(A_LIMIT, 32'd77);
        rd_check("R2 writable after por", A_LIMIT, 32'd77);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #50000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_por();
        t_reset();
        t_unlocked_writes();
        t_sdctl();
        t_temp_ro();
        t_trip();
        t_lock();
        t_warm();
        t_unmapped();
        t_por_again();
        finish_run();
    end
endmodule